// File: doc/BRIEF.md
# Unified Instruction/Data Memory Port Arbiter

This block sits at the front of a five-stage pipeline (IF, ID, EX, MEM, WB) in which a single memory array holds both instructions and data. Every cycle it looks at the fetch request from IF and at the load and store flags of the instruction that currently occupies MEM. It then hands the one memory port to a single requester. A data access always wins the port. Fetch is denied only in cycles where the MEM-stage instruction really reads or writes memory. ALU operations and branches in MEM leave fetch untouched.

The block steers address, write data and write enable onto the port. It routes the returned word either into the IF/ID register it owns or into a register that feeds WB. It also tells the rest of the pipeline what to do: hold the PC so that the denied address is fetched again, and put a no-op bubble into IF/ID. The array answers within the cycle: reads are combinational and writes commit at the clock edge.

A three-state machine records what IF/ID holds:
- `IFID_EMPTY`: nothing was requested.
- `IFID_INSN`: a fetched word.
- `IFID_BUBBLE`: a fetch was denied.

The machine has three transitions, each taken from any state:
- T_FETCH leads to `IFID_INSN` when fetch owns the port.
- T_STALL leads to `IFID_BUBBLE` when a data access displaces a pending fetch.
- T_IDLE leads to `IFID_EMPTY` when nothing asks for a fetch.

Port ownership per cycle is one of `OWN_NONE`, `OWN_FETCH`, `OWN_LOAD` or `OWN_STORE`.

Top module: `unified_port_arbiter`

## Requirements
- R1: While reset is asserted and after it is released, `ifid_insn` reads the no-op word 0x00000013, `ifid_valid` is 0 and `wb_valid` is 0. Reset does not clear the memory contents.
- R2: When `dmem_load` is 1 (and `dmem_store` is 0), the port reads `dmem_addr`, and in that same cycle `pc_hold`=1 and `ifid_load`=0. After the next clock edge, `wb_valid`=1 and `wb_data` equals the word stored at `dmem_addr`.
- R3: When `dmem_store` is 1, `pc_hold` is 1 in that cycle and `dmem_wdata` is written to `dmem_addr` at the clock edge. Cycles that perform only a load or only a fetch never modify memory, whatever `dmem_wdata` holds.
- R4: When neither data flag is set and `fetch_req` is 1, `pc_hold`=0 and `ifid_load`=1. After the clock edge, `ifid_insn` equals the word at `fetch_addr` and `ifid_valid`=1.
- R5: When a load or store displaces a fetch request, `bubble_ins` is 1 in that cycle. After the edge, `ifid_insn` is 0x00000013 with `ifid_valid`=0.
- R6: When there is no request at all, `pc_hold`, `bubble_ins` and `ifid_load` are 0. After the edge, IF/ID holds 0x00000013 with `ifid_valid`=0.
- R7: If `dmem_load` and `dmem_store` are both 1, the cycle is treated as a store: the write commits, and `wb_valid` is 0 after the edge.
- R8: The whole address range is reachable through both fetch and data access, including the highest word 2^AW-1.
- R9: After every cycle that performs no load, `wb_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | IF wants an instruction this cycle |
| fetch_addr | input | AW | Word address from the PC |
| dmem_load | input | 1 | MEM-stage instruction is a load |
| dmem_store | input | 1 | MEM-stage instruction is a store |
| dmem_addr | input | AW | Word address of the data access |
| dmem_wdata | input | DW | Store data |
| pc_hold | output | 1 | PC must keep its value this cycle |
| ifid_load | output | 1 | IF/ID captures a fetched word at the edge |
| bubble_ins | output | 1 | A no-op replaces a denied fetch in IF/ID |
| ifid_insn | output | DW | IF/ID instruction register |
| ifid_valid | output | 1 | IF/ID holds a real fetched word |
| wb_data | output | DW | Load result handed to WB |
| wb_valid | output | 1 | `wb_data` was loaded in the previous cycle |

## Verification
The hardest condition to reach from the ports is proving that a denied fetch leaves no trace and that a load does not write. The bench presents a fetch address together with a load whose write-data bus carries a poison value. In the following cycle it fetches that same address again. The word returned must still be the one stored earlier, and the refetch must show that the held PC produces the correct instruction. The both-flags case and the highest address are reached the same way, by writing through a store and reading back through a later fetch or load.

// File: rtl/umarb_pkg.sv
package umarb_pkg;

    typedef enum logic [1:0] {
        OWN_NONE,
        OWN_FETCH,
        OWN_LOAD,
        OWN_STORE
    } port_owner_e;

    typedef enum logic [1:0] {
        IFID_EMPTY,
        IFID_INSN,
        IFID_BUBBLE
    } ifid_state_e;

endpackage

// File: rtl/umarb_grant.sv
module umarb_grant
    import umarb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fetch_req,
    input  logic        ld_req,
    input  logic        st_req,
    output port_owner_e owner,
    output logic        pc_hold,
    output logic        ifid_load,
    output logic        bubble_ins,
    output logic        ifid_valid
);

    ifid_state_e state_q;
    ifid_state_e state_d;

    // Ownership: a store beats a load, and any data access beats a fetch.
    always_comb begin
        if (st_req)         owner = OWN_STORE;
        else if (ld_req)    owner = OWN_LOAD;
        else if (fetch_req) owner = OWN_FETCH;
        else                owner = OWN_NONE;
    end

    // Transition selection: T_FETCH, T_STALL or T_IDLE.
    always_comb begin
        unique case (owner)
            OWN_FETCH:           state_d = IFID_INSN;
            OWN_LOAD, OWN_STORE: state_d = fetch_req ? IFID_BUBBLE : IFID_EMPTY;
            OWN_NONE:            state_d = IFID_EMPTY;
            default:             state_d = IFID_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IFID_EMPTY;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        pc_hold    = 1'b0;
        ifid_load  = 1'b0;
        bubble_ins = 1'b0;
        unique case (owner)
            OWN_FETCH: ifid_load = 1'b1;
            OWN_LOAD, OWN_STORE: begin
                pc_hold    = 1'b1;
                bubble_ins = fetch_req;
            end
            default: ;
        endcase

        unique case (state_q)
            IFID_INSN:   ifid_valid = 1'b1;
            IFID_EMPTY:  ifid_valid = 1'b0;
            IFID_BUBBLE: ifid_valid = 1'b0;
            default:     ifid_valid = 1'b0;
        endcase
    end

    // R5
    bubble_to_ifid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_ins |=> !ifid_valid);

    // R4
    fetch_to_ifid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_load |=> ifid_valid);

    // R2
    data_holds_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req || st_req) |-> (pc_hold && !ifid_load));

endmodule

// File: rtl/umarb_portmux.sv
module umarb_portmux
    import umarb_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  port_owner_e     owner,
    input  logic [AW-1:0]   fetch_addr,
    input  logic [AW-1:0]   data_addr,
    input  logic [DW-1:0]   data_wdata,
    output logic [AW-1:0]   port_addr,
    output logic [DW-1:0]   port_wdata,
    output logic            port_we
);

    always_comb begin
        port_wdata = data_wdata;
        unique case (owner)
            OWN_STORE: begin
                port_addr = data_addr;
                port_we   = 1'b1;
            end
            OWN_LOAD: begin
                port_addr = data_addr;
                port_we   = 1'b0;
            end
            OWN_FETCH: begin
                port_addr = fetch_addr;
                port_we   = 1'b0;
            end
            OWN_NONE: begin
                port_addr = fetch_addr;
                port_we   = 1'b0;
            end
            default: begin
                port_addr = fetch_addr;
                port_we   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/umarb_ram.sv
module umarb_ram #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/umarb_route.sv
module umarb_route
    import umarb_pkg::*;
#(
    parameter int          DW          = 32,
    parameter logic [31:0] BUBBLE_WORD = 32'h0000_0013
) (
    input  logic          clk,
    input  logic          rst_n,
    input  port_owner_e   owner,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] ifid_insn,
    output logic [DW-1:0] wb_data,
    output logic          wb_valid
);

    localparam logic [DW-1:0] NOP_W = DW'(BUBBLE_WORD);

    // The fetched word goes to IF/ID; every other cycle leaves a no-op there.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ifid_insn <= NOP_W;
        else        ifid_insn <= (owner == OWN_FETCH) ? rdata : NOP_W;
    end

    // A load result travels to WB.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_data  <= '0;
            wb_valid <= 1'b0;
        end else begin
            wb_valid <= (owner == OWN_LOAD);
            if (owner == OWN_LOAD) wb_data <= rdata;
        end
    end

    // R2
    load_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_LOAD) |=> wb_valid);

    // R6
    idle_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_NONE) |=> (ifid_insn == NOP_W));

    // R9
    no_load_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owner != OWN_LOAD) |=> !wb_valid);

endmodule

// File: rtl/unified_port_arbiter.sv
module unified_port_arbiter
    import umarb_pkg::*;
#(
    parameter int          AW          = 8,
    parameter int          DW          = 32,
    parameter logic [31:0] BUBBLE_WORD = 32'h0000_0013
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_req,
    input  logic [AW-1:0] fetch_addr,
    input  logic          dmem_load,
    input  logic          dmem_store,
    input  logic [AW-1:0] dmem_addr,
    input  logic [DW-1:0] dmem_wdata,
    output logic          pc_hold,
    output logic          ifid_load,
    output logic          bubble_ins,
    output logic [DW-1:0] ifid_insn,
    output logic          ifid_valid,
    output logic [DW-1:0] wb_data,
    output logic          wb_valid
);

    port_owner_e   owner;
    logic [AW-1:0] port_addr;
    logic [DW-1:0] port_wdata;
    logic          port_we;
    logic [DW-1:0] port_rdata;

    umarb_grant u_grant (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_req  (fetch_req),
        .ld_req     (dmem_load),
        .st_req     (dmem_store),
        .owner      (owner),
        .pc_hold    (pc_hold),
        .ifid_load  (ifid_load),
        .bubble_ins (bubble_ins),
        .ifid_valid (ifid_valid)
    );

    umarb_portmux #(.AW(AW), .DW(DW)) u_mux (
        .owner      (owner),
        .fetch_addr (fetch_addr),
        .data_addr  (dmem_addr),
        .data_wdata (dmem_wdata),
        .port_addr  (port_addr),
        .port_wdata (port_wdata),
        .port_we    (port_we)
    );

    umarb_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (port_we),
        .addr  (port_addr),
        .wdata (port_wdata),
        .rdata (port_rdata)
    );

    umarb_route #(.DW(DW), .BUBBLE_WORD(BUBBLE_WORD)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .owner     (owner),
        .rdata     (port_rdata),
        .ifid_insn (ifid_insn),
        .wb_data   (wb_data),
        .wb_valid  (wb_valid)
    );

    // R3
    write_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_we |-> (dmem_store && port_addr == dmem_addr && !ifid_load));

    // R7
    both_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_load && dmem_store) |=> !wb_valid);

endmodule

// File: tb/tb_unified_port_arbiter.sv
module tb_unified_port_arbiter;

    localparam int          AW  = 8;
    localparam int          DW  = 32;
    localparam logic [31:0] NOP = 32'h0000_0013;

    typedef struct packed {
        logic          freq;
        logic [AW-1:0] fa;
        logic          ld;
        logic          st;
        logic [AW-1:0] ma;
        logic [DW-1:0] wd;
        logic          x_hold;
        logic          x_bub;
        logic          x_iv;
        logic [DW-1:0] x_insn;
        logic          x_wv;
        logic [DW-1:0] x_wd;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h00, 1'b0, 1'b1, 8'h10, 32'hA1A1_0001, 1'b1, 1'b1, 1'b0, NOP,          1'b0, 32'h0},
        '{1'b0, 8'h00, 1'b0, 1'b1, 8'h11, 32'hB2B2_0002, 1'b1, 1'b0, 1'b0, NOP,          1'b0, 32'h0},
        '{1'b1, 8'h00, 1'b0, 1'b1, 8'h20, 32'h1234_5678, 1'b1, 1'b1, 1'b0, NOP,          1'b0, 32'h0},
        '{1'b1, 8'h10, 1'b0, 1'b0, 8'h00, 32'h0,         1'b0, 1'b0, 1'b1, 32'hA1A1_0001, 1'b0, 32'h0},
        '{1'b1, 8'h11, 1'b1, 1'b0, 8'h20, 32'h0,         1'b1, 1'b1, 1'b0, NOP,          1'b1, 32'h1234_5678},
        '{1'b1, 8'h11, 1'b0, 1'b0, 8'h00, 32'h0,         1'b0, 1'b0, 1'b1, 32'hB2B2_0002, 1'b0, 32'h0},
        '{1'b0, 8'h00, 1'b1, 1'b0, 8'h11, 32'hDEAD_BEEF, 1'b1, 1'b0, 1'b0, NOP,          1'b1, 32'hB2B2_0002},
        '{1'b1, 8'h11, 1'b0, 1'b0, 8'h00, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b1, 32'hB2B2_0002, 1'b0, 32'h0},
        '{1'b1, 8'h10, 1'b1, 1'b1, 8'h30, 32'h0BAD_F00D, 1'b1, 1'b1, 1'b0, NOP,          1'b0, 32'h0},
        '{1'b0, 8'h00, 1'b1, 1'b0, 8'h30, 32'h0,         1'b1, 1'b0, 1'b0, NOP,          1'b1, 32'h0BAD_F00D},
        '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 32'h0,         1'b0, 1'b0, 1'b0, NOP,          1'b0, 32'h0},
        '{1'b1, 8'h30, 1'b0, 1'b0, 8'h00, 32'h0,         1'b0, 1'b0, 1'b1, 32'h0BAD_F00D, 1'b0, 32'h0},
        '{1'b1, 8'hFF, 1'b0, 1'b1, 8'hFF, 32'hFFFF_0000, 1'b1, 1'b1, 1'b0, NOP,          1'b0, 32'h0},
        '{1'b1, 8'hFF, 1'b0, 1'b0, 8'h00, 32'h0,         1'b0, 1'b0, 1'b1, 32'hFFFF_0000, 1'b0, 32'h0},
        '{1'b0, 8'h00, 1'b1, 1'b0, 8'hFF, 32'h0,         1'b1, 1'b0, 1'b0, NOP,          1'b1, 32'hFFFF_0000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_req = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic          dmem_load = 1'b0;
    logic          dmem_store = 1'b0;
    logic [AW-1:0] dmem_addr = '0;
    logic [DW-1:0] dmem_wdata = '0;
    logic          pc_hold, ifid_load, bubble_ins, ifid_valid, wb_valid;
    logic [DW-1:0] ifid_insn, wb_data;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    unified_port_arbiter #(.AW(AW), .DW(DW), .BUBBLE_WORD(NOP)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_req  (fetch_req),
        .fetch_addr (fetch_addr),
        .dmem_load  (dmem_load),
        .dmem_store (dmem_store),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .pc_hold    (pc_hold),
        .ifid_load  (ifid_load),
        .bubble_ins (bubble_ins),
        .ifid_insn  (ifid_insn),
        .ifid_valid (ifid_valid),
        .wb_data    (wb_data),
        .wb_valid   (wb_valid)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input int i);
        case (i)
            6, 7:       return "R3";
            8:          return "R7";
            10:         return "R6";
            12, 13, 14: return "R8";
            default:    return "R4";
        endcase
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        // R1: values while reset is asserted
        repeat (2) @(negedge clk);
        #1;
        chk("R1 ifid_insn in reset", ifid_insn, NOP);
        chk("R1 ifid_valid in reset", {31'b0, ifid_valid}, 32'd0);
        chk("R1 wb_valid in reset", {31'b0, wb_valid}, 32'd0);
        chk("R6 pc_hold idle", {31'b0, pc_hold}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string t;
            t = tag_of(i);
            @(negedge clk);
            fetch_req  = VECS[i].freq;
            fetch_addr = VECS[i].fa;
            dmem_load  = VECS[i].ld;
            dmem_store = VECS[i].st;
            dmem_addr  = VECS[i].ma;
            dmem_wdata = VECS[i].wd;
            #1;
            chk($sformatf("R2 %s v%0d pc_hold", t, i), {31'b0, pc_hold}, {31'b0, VECS[i].x_hold});
            chk($sformatf("R5 %s v%0d bubble_ins", t, i), {31'b0, bubble_ins}, {31'b0, VECS[i].x_bub});
            chk($sformatf("R4 %s v%0d ifid_load", t, i), {31'b0, ifid_load},
                {31'b0, VECS[i].freq & ~VECS[i].ld & ~VECS[i].st});
            @(posedge clk);
            #2;
            chk($sformatf("R4 %s v%0d ifid_valid", t, i), {31'b0, ifid_valid}, {31'b0, VECS[i].x_iv});
            chk($sformatf("R4 %s v%0d ifid_insn", t, i), ifid_insn, VECS[i].x_insn);
            chk($sformatf("R9 %s v%0d wb_valid", t, i), {31'b0, wb_valid}, {31'b0, VECS[i].x_wv});
            if (VECS[i].x_wv)
                chk($sformatf("R2 %s v%0d wb_data", t, i), wb_data, VECS[i].x_wd);
        end

        // R1: reset in mid-run clears IF/ID and WB, memory survives
        @(negedge clk);
        fetch_req = 1'b0; dmem_store = 1'b0; dmem_load = 1'b1; dmem_addr = 8'h10;
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = 8'h20; dmem_load = 1'b0;
        @(posedge clk);
        #2;
        chk("R2 wb_valid before reset", {31'b0, wb_valid}, 32'd0);
        chk("R4 ifid_insn before reset", ifid_insn, 32'h1234_5678);
        @(negedge clk);
        rst_n = 1'b0;
        fetch_req = 1'b0;
        #1;
        chk("R1 ifid_valid mid reset", {31'b0, ifid_valid}, 32'd0);
        chk("R1 ifid_insn mid reset", ifid_insn, NOP);
        @(negedge clk);
        rst_n = 1'b1;
        fetch_req = 1'b1; fetch_addr = 8'h10;
        @(posedge clk);
        #2;
        chk("R1 memory kept through reset", ifid_insn, 32'hA1A1_0001);
        chk("R1 ifid_valid after reset", {31'b0, ifid_valid}, 32'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule